// File: doc/BRIEF.md
# Load/Store Address Generator

This unit turns the operand fields of a memory-transfer operation into the byte address that goes to the bus. It also produces the value, if any, that is written back into the base register. A request carries the following fields:

- the base register number and its value;
- the number of the register being loaded or stored;
- the address of the current instruction;
- an offset source, which is either a 12-bit unsigned immediate or a register value shifted left by a 5-bit amount;
- an add/subtract select;
- an indexing mode.

The unit adds or subtracts the offset, chooses between the sum and the unmodified base according to the mode, and flags encodings that must not be executed. It never touches a register file or memory. A later stage uses its outputs for those.

Requests enter on a valid/ready handshake and results leave on a valid/ready handshake through one output register. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every result field is held. When the base register is number 15, the unit ignores the supplied base value and uses the instruction address instead, advanced and word-aligned.

Top module: `agu_top`

## Requirements
- R1: Mode 0 (plain offset) gives address = base + offset, or base − offset when `in_sub`=1, with `out_wb_en`=0.
- R2: Mode 1 (pre-indexed) gives address = base ± offset, `out_wb_val` equal to that address, and `out_wb_en`=1 when legal.
- R3: Mode 2 (post-indexed) gives address = the unmodified base, `out_wb_val` = base ± offset, and `out_wb_en`=1 when legal.
- R4: With `in_use_reg`=0 the offset is `in_imm` zero-extended to 32 bits, so 0xFFF is the largest magnitude. Subtraction wraps modulo 2^32.
- R5: With `in_use_reg`=1 the offset is `in_reg_val` shifted left by `in_shamt` (0..31), with bits shifted past bit 31 lost.
- R6: When `in_base_idx`=15 the base is (`in_pc` + 4) with bits [1:0] cleared, and `in_base_val` has no effect.
- R7: Base index 15 with mode 1 or 2 sets `out_illegal`=1 and `out_wb_en`=0. The address still follows the mode.
- R8: `in_base_idx` equal to `in_xfer_idx` with mode 1 or 2 sets `out_illegal`=1 and `out_wb_en`=0. In mode 0 the same pair is legal.
- R9: Mode 3 is reserved. It sets `out_illegal`=1 and `out_wb_en`=0 and forms the address as in mode 0.
- R10: A result appears on the outputs with `out_valid`=1 in the cycle after its request is accepted. `in_ready` = !`out_valid` || `out_ready`.
- R11: While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and all result fields stay unchanged.
- R12: During and straight after reset `out_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_base_idx | input | 4 | Base register number (15 = program counter) |
| in_base_val | input | 32 | Base register contents |
| in_xfer_idx | input | 4 | Register being loaded or stored |
| in_pc | input | 32 | Address of the current instruction |
| in_use_reg | input | 1 | 1 = shifted register offset, 0 = immediate |
| in_imm | input | 12 | Unsigned immediate offset |
| in_reg_val | input | 32 | Offset register contents |
| in_shamt | input | 5 | Left-shift amount for the register offset |
| in_sub | input | 1 | 1 = subtract offset, 0 = add |
| in_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 reserved |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Effective bus address |
| out_wb_en | output | 1 | Base register writeback enable |
| out_wb_val | output | 32 | Value for base register writeback |
| out_illegal | output | 1 | Encoding must not execute |

## Verification
Every result field is due exactly one clock after the edge that accepts its request, and stays due for as long as `out_ready` holds it. The driver records the expected result in the scoreboard at the moment it sees `in_ready` high ahead of the accepting edge. The monitor takes an entry off only at a falling edge where both `out_valid` and `out_ready` are high, which is exactly the point where that result leaves. A separate check, with the output idle and `out_ready` high, confirms that `out_valid` rises at the first falling edge after acceptance. The stall check compares every field across each cycle in which `out_ready` was low.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 4;
  localparam int IMM_W    = 12;
  localparam int SH_W     = 5;
  localparam int PC_IDX   = 15;
  localparam int PC_ADV   = 4;
  localparam int ALIGN_LG = 2;

  typedef enum logic [1:0] {
    MODE_OFS  = 2'd0,
    MODE_PRE  = 2'd1,
    MODE_POST = 2'd2,
    MODE_RSV  = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic              use_reg,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] offset
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] reg_shf;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{1'b0}}, imm};
    end else begin : g_nopad
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  // R5: barrel shift left, bits past the top are dropped
  assign reg_shf = reg_val << shamt;
  assign offset  = use_reg ? reg_shf : imm_ext;
endmodule

// File: rtl/agu_base.sv
module agu_base #(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter int PC_IDX   = 15,
  parameter int PC_ADV   = 4,
  parameter int ALIGN_LG = 2
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] pc,
  output logic              is_pc,
  output logic [DATA_W-1:0] eff_base
);
  localparam logic [DATA_W-1:0] ADV_C  = DATA_W'(PC_ADV);
  localparam logic [DATA_W-1:0] ALIGN_M = ~DATA_W'((1 << ALIGN_LG) - 1);

  logic [DATA_W-1:0] pc_read;

  assign is_pc    = (base_idx == IDX_W'(PC_IDX));
  assign pc_read  = (pc + ADV_C) & ALIGN_M;   // R6
  assign eff_base = is_pc ? pc_read : base_val;
endmodule

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic [DATA_W-1:0] eff_base,
  input  logic [DATA_W-1:0] offset,
  input  logic              sub,
  input  agu_mode_e         mode,
  input  logic              is_pc,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [IDX_W-1:0]  xfer_idx,
  output logic [DATA_W-1:0] addr,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_val,
  output logic              illegal
);
  logic [DATA_W-1:0] sum;
  logic              wb_req;
  logic              clash;

  always_comb begin
    sum     = sub ? (eff_base - offset) : (eff_base + offset);
    wb_req  = (mode == MODE_PRE) || (mode == MODE_POST);
    clash   = is_pc || (base_idx == xfer_idx);           // R7 R8
    illegal = (mode == MODE_RSV) || (wb_req && clash);   // R9
    wb_en   = wb_req && !illegal;
    wb_val  = sum;
    addr    = (mode == MODE_POST) ? eff_base : sum;      // R3
  end
endmodule

// File: rtl/agu_outreg.sv
module agu_outreg #(
  parameter int PW = 66
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          vld_q;
  logic [PW-1:0] dat_q;
  logic          fire;

  assign in_ready  = !vld_q || out_ready;
  assign fire      = in_valid && in_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (fire) begin
        vld_q <= 1'b1;
        dat_q <= in_data;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(dat_q))); // R11

  AST_FILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> vld_q); // R10
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int DW  = agu_pkg::DATA_W,
  parameter int IW  = agu_pkg::IDX_W,
  parameter int MW  = agu_pkg::IMM_W,
  parameter int SW  = agu_pkg::SH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_base_idx,
  input  logic [DW-1:0] in_base_val,
  input  logic [IW-1:0] in_xfer_idx,
  input  logic [DW-1:0] in_pc,
  input  logic          in_use_reg,
  input  logic [MW-1:0] in_imm,
  input  logic [DW-1:0] in_reg_val,
  input  logic [SW-1:0] in_shamt,
  input  logic          in_sub,
  input  logic [1:0]    in_mode,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_addr,
  output logic          out_wb_en,
  output logic [DW-1:0] out_wb_val,
  output logic          out_illegal
);
  localparam int PW = 2 * DW + 2;

  agu_mode_e     mode;
  logic [DW-1:0] offset;
  logic [DW-1:0] eff_base;
  logic          is_pc;
  logic [DW-1:0] c_addr;
  logic          c_wb_en;
  logic [DW-1:0] c_wb_val;
  logic          c_illegal;
  logic [PW-1:0] pay_in;
  logic [PW-1:0] pay_out;
  logic          fire;

  assign mode = agu_mode_e'(in_mode);

  agu_offset #(.DATA_W(DW), .IMM_W(MW), .SH_W(SW)) u_off (
    .use_reg (in_use_reg),
    .imm     (in_imm),
    .reg_val (in_reg_val),
    .shamt   (in_shamt),
    .offset  (offset)
  );

  agu_base #(.DATA_W(DW), .IDX_W(IW), .PC_IDX(PC_IDX), .PC_ADV(PC_ADV),
             .ALIGN_LG(ALIGN_LG)) u_base (
    .base_idx (in_base_idx),
    .base_val (in_base_val),
    .pc       (in_pc),
    .is_pc    (is_pc),
    .eff_base (eff_base)
  );

  agu_calc #(.DATA_W(DW), .IDX_W(IW)) u_calc (
    .eff_base (eff_base),
    .offset   (offset),
    .sub      (in_sub),
    .mode     (mode),
    .is_pc    (is_pc),
    .base_idx (in_base_idx),
    .xfer_idx (in_xfer_idx),
    .addr     (c_addr),
    .wb_en    (c_wb_en),
    .wb_val   (c_wb_val),
    .illegal  (c_illegal)
  );

  assign pay_in = {c_addr, c_wb_en, c_wb_val, c_illegal};

  agu_outreg #(.PW(PW)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_addr, out_wb_en, out_wb_val, out_illegal} = pay_out;
  assign fire = in_valid && in_ready;

  AST_NO_WB_WHEN_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_wb_en && out_illegal)); // R7

  AST_PC_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_pc) |-> (eff_base[ALIGN_LG-1:0] == '0)); // R6

  AST_OFS_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == MODE_OFS) |=> !out_wb_en); // R1

  AST_POST_ADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == MODE_POST) |=> (out_addr == $past(eff_base))); // R3

  AST_PRE_ADDR_IS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == MODE_PRE) |=> (out_addr == out_wb_val)); // R2

  AST_SAME_REG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (mode == MODE_PRE || mode == MODE_POST) && in_base_idx == in_xfer_idx)
      |=> (out_illegal && !out_wb_en)); // R8

  AST_RSV_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == MODE_RSV) |=> out_illegal); // R9
endmodule

// File: tb/agu_top_bench.sv
module agu_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_base_idx = '0;
  logic [31:0] in_base_val = '0;
  logic [3:0]  in_xfer_idx = '0;
  logic [31:0] in_pc = '0;
  logic        in_use_reg = 1'b0;
  logic [11:0] in_imm = '0;
  logic [31:0] in_reg_val = '0;
  logic [4:0]  in_shamt = '0;
  logic        in_sub = 1'b0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_wb_en;
  logic [31:0] out_wb_val;
  logic        out_illegal;

  always #2.5 clk = ~clk;

  agu_top u_agu_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base_idx(in_base_idx), .in_base_val(in_base_val),
    .in_xfer_idx(in_xfer_idx), .in_pc(in_pc), .in_use_reg(in_use_reg),
    .in_imm(in_imm), .in_reg_val(in_reg_val), .in_shamt(in_shamt),
    .in_sub(in_sub), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_wb_en(out_wb_en),
    .out_wb_val(out_wb_val), .out_illegal(out_illegal)
  );

  typedef struct {
    logic [31:0] addr;
    logic        wb;
    logic [31:0] wbv;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  bit   rand_rdy = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  // consumer back-pressure, changed just after the rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = rand_rdy ? lfsr[0] : 1'b1;
  end

  function automatic exp_t model(input logic [3:0] bi, input logic [31:0] bv,
      input logic [3:0] xi, input logic [31:0] pc, input logic ur,
      input logic [11:0] im, input logic [31:0] rv, input logic [4:0] sh,
      input logic sb, input logic [1:0] md, input string tag);
    exp_t e;
    logic [31:0] b, o, s;
    logic wr;
    b = (bi == 4'd15) ? ((pc + 32'd4) & 32'hFFFF_FFFC) : bv;
    o = ur ? (rv << sh) : {20'd0, im};
    s = sb ? b - o : b + o;
    wr = (md == 2'd1) || (md == 2'd2);
    e.ill  = (md == 2'd3) || (wr && ((bi == 4'd15) || (bi == xi)));
    e.wb   = wr && !e.ill;
    e.wbv  = s;
    e.addr = (md == 2'd2) ? b : s;
    e.tag  = tag;
    return e;
  endfunction

  // driver: called at a falling edge, returns at the falling edge after acceptance
  task automatic drive(input logic [3:0] bi, input logic [31:0] bv,
      input logic [3:0] xi, input logic [31:0] pc, input logic ur,
      input logic [11:0] im, input logic [31:0] rv, input logic [4:0] sh,
      input logic sb, input logic [1:0] md, input string tag);
    in_base_idx = bi; in_base_val = bv; in_xfer_idx = xi; in_pc = pc;
    in_use_reg = ur; in_imm = im; in_reg_val = rv; in_shamt = sh;
    in_sub = sb; in_mode = md; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q.push_back(model(bi, bv, xi, pc, ur, im, rv, sh, sb, md, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  bit          stall_prev = 1'b0;
  logic [31:0] s_addr, s_wbv;
  logic        s_wb, s_ill;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        total++;
        if (!out_valid || out_addr !== s_addr || out_wb_en !== s_wb ||
            out_wb_val !== s_wbv || out_illegal !== s_ill) begin
          bad++;
          $display("FAIL R11 stall hold: got v=%0b a=%h wb=%0b wv=%h il=%0b exp v=1 a=%h wb=%0b wv=%h il=%0b",
                   out_valid, out_addr, out_wb_en, out_wb_val, out_illegal,
                   s_addr, s_wb, s_wbv, s_ill);
        end
      end
      stall_prev = out_valid && !out_ready;
      s_addr = out_addr; s_wb = out_wb_en; s_wbv = out_wb_val; s_ill = out_illegal;
      if (out_valid && out_ready) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R10 unexpected result: got a=%h exp none", out_addr);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (out_addr !== e.addr || out_wb_en !== e.wb ||
              out_wb_val !== e.wbv || out_illegal !== e.ill) begin
            bad++;
            $display("FAIL %s: got a=%h wb=%0b wv=%h il=%0b exp a=%h wb=%0b wv=%h il=%0b",
                     e.tag, out_addr, out_wb_en, out_wb_val, out_illegal,
                     e.addr, e.wb, e.wbv, e.ill);
          end
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R12 reset: got v=%b rdy=%b exp v=0 rdy=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R12 after reset: got v=%b exp 0", out_valid);
    end

    // R10 latency from idle
    drive(4'd1, 32'h0000_1000, 4'd2, 32'h0, 1'b0, 12'h010, 32'h0, 5'd0, 1'b0, 2'd0, "R1 ofs add");
    total++;
    if (out_valid !== 1'b1) begin
      bad++;
      $display("FAIL R10 latency: got v=%b exp 1", out_valid);
    end
    @(negedge clk);

    drive(4'd1, 32'h0000_1000, 4'd2, 32'h0, 1'b0, 12'h010, 32'h0, 5'd0, 1'b1, 2'd0, "R1 ofs sub");
    drive(4'd3, 32'h2000_0000, 4'd4, 32'h0, 1'b1, 12'h0, 32'h0000_0005, 5'd2, 1'b0, 2'd1, "R2 pre reg shl2");
    drive(4'd3, 32'h2000_0000, 4'd4, 32'h0, 1'b0, 12'h024, 32'h0, 5'd0, 1'b0, 2'd2, "R3 post imm");
    drive(4'd5, 32'h0000_0008, 4'd6, 32'h0, 1'b0, 12'hFFF, 32'h0, 5'd0, 1'b1, 2'd1, "R4 max imm sub wrap");
    drive(4'd5, 32'h0000_0000, 4'd6, 32'h0, 1'b0, 12'hFFF, 32'hFFFF_FFFF, 5'd0, 1'b0, 2'd0, "R4 imm zero-ext");
    drive(4'd5, 32'h0000_0100, 4'd6, 32'h0, 1'b1, 12'h0, 32'h0000_0003, 5'd0, 1'b0, 2'd0, "R5 shift 0");
    drive(4'd5, 32'h0000_0100, 4'd6, 32'h0, 1'b1, 12'h0, 32'h0000_0003, 5'd31, 1'b0, 2'd0, "R5 shift 31");
    drive(4'd15, 32'hDEAD_BEEF, 4'd0, 32'h0000_1003, 1'b0, 12'h008, 32'h0, 5'd0, 1'b0, 2'd0, "R6 pc base ofs");
    drive(4'd15, 32'h1234_5678, 4'd0, 32'h0000_2000, 1'b0, 12'h004, 32'h0, 5'd0, 1'b1, 2'd0, "R6 pc base sub");
    drive(4'd15, 32'h0, 4'd0, 32'h0000_3002, 1'b0, 12'h004, 32'h0, 5'd0, 1'b0, 2'd1, "R7 pc pre");
    drive(4'd15, 32'h0, 4'd0, 32'h0000_3002, 1'b0, 12'h004, 32'h0, 5'd0, 1'b0, 2'd2, "R7 pc post");
    drive(4'd7, 32'h0000_4000, 4'd7, 32'h0, 1'b0, 12'h004, 32'h0, 5'd0, 1'b0, 2'd1, "R8 same reg pre");
    drive(4'd7, 32'h0000_4000, 4'd7, 32'h0, 1'b0, 12'h004, 32'h0, 5'd0, 1'b0, 2'd2, "R8 same reg post");
    drive(4'd7, 32'h0000_4000, 4'd7, 32'h0, 1'b0, 12'h004, 32'h0, 5'd0, 1'b0, 2'd0, "R8 same reg ofs legal");
    drive(4'd8, 32'h0000_5000, 4'd9, 32'h0, 1'b0, 12'h00C, 32'h0, 5'd0, 1'b0, 2'd3, "R9 reserved mode");

    // back-pressure stream: R10 R11 plus mixed modes
    rand_rdy = 1'b1;
    for (int i = 0; i < 40; i++) begin
      drive(4'(i % 16), 32'h0001_0000 * i, 4'((i * 7) % 16), 32'h0000_8000 + i,
            1'(i % 2), 12'(i * 37), 32'(i * 3 + 1), 5'(i % 32), 1'(i / 3 % 2),
            2'(i % 4), "R10 R11 stream");
    end
    rand_rdy = 1'b0;
    repeat (10) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R10 drain: got %0d left exp 0", q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule